// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This block collects event flags for a serial bus controller and turns them into one level interrupt line and two DMA request lines. The transfer engine reports events as single-cycle set pulses on a 16-bit bus. Each pulse latches a bit in a status register. Software sees four registers through a small read/write strobe interface: status, interrupt enable, vector and DMA configuration.

Software can clear status bits in two ways. It can write ones to the status register, which clears only the bits the hardware allows software to clear. It can also read the vector register, which returns the 1-based position of the lowest pending enabled source and clears that source in the same access. A status read inserts the live bus-busy level at bit 12; that bit is never stored. Turning on DMA for a direction also clears that direction's ready-interrupt enable, so the DMA engine and the CPU do not both service the same event.

Top module: `intr_vec_unit`

## Requirements
- R1: After reset, status, enable and both DMA enables read as zero, and `irq_o`, `rx_dma_o` and `tx_dma_o` are low.
- R2: A one on `set_i[b]` sets status bit b at the next edge, except bit 12, which is never stored.
- R3: Reading status (`reg_sel_i` = 0) returns the stored status with `bus_busy_i` in bit 12.
- R4: Writing status clears exactly the bits where the written value is 1 and the clearable mask 0x63E7 is 1. Bits 3 (receive ready), 4 (transmit ready), 10, 11 and 15 are left unchanged by such a write.
- R5: Writing enable (`reg_sel_i` = 1) stores the written value ANDed with 0x63FF, and reading enable returns the stored value.
- R6: `irq_o` equals the OR-reduction of (status AND enable) as it stood one cycle earlier.
- R7: Reading the vector register (`reg_sel_i` = 2) returns the 1-based index of the lowest set bit of (status AND enable), or 0 when none is set. The same access clears that status bit.
- R8: `rx_dma_o` equals status bit 3 ANDed with DMA configuration bit 15, and `tx_dma_o` equals status bit 4 ANDed with configuration bit 7, both as they stood one cycle earlier. The configuration register (`reg_sel_i` = 3) reads back only bits 15 and 7.
- R9: Writing configuration with bit 15 set clears enable bit 3. Writing it with bit 7 set clears enable bit 4.
- R10: A set pulse on a bit wins over a software clear of the same bit in the same cycle, whether the clear comes from a status write or from a vector read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 16 | Event set pulses from the transfer engine |
| reg_sel_i | input | 2 | Register select: 0 status, 1 enable, 2 vector, 3 DMA config |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe (causes the side effect of a vector read) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for the selected register (combinational) |
| bus_busy_i | input | 1 | Live bus-busy level |
| irq_o | output | 1 | Level interrupt |
| rx_dma_o | output | 1 | Receive DMA request |
| tx_dma_o | output | 1 | Transmit DMA request |

## Verification
A corrupted status or enable bit shows up at `irq_o` on the very next clock edge. The status and vector reads expose it in the same cycle. A wrong priority encode shows as a wrong vector value, and a wrong clear shows as a repeated value on the following vector read. A lost enable clear after a DMA configuration write shows as an interrupt that stays asserted while the DMA request is active. A lost set-over-clear priority shows as a bit that is missing from the next status read.

// File: rtl/intr_pkg.sv
package intr_pkg;
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_IE   = 2'd1,
    SEL_VEC  = 2'd2,
    SEL_CFG  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/intr_prio_enc.sv
module intr_prio_enc #(
  parameter int DW = 16,
  localparam int VW = $clog2(DW + 1)
) (
  input  logic [DW-1:0] req_i,
  output logic [DW-1:0] hit_o,
  output logic [VW-1:0] idx_o
);
  logic [DW:0] none_below;
  assign none_below[0] = 1'b1;

  for (genvar i = 0; i < DW; i++) begin : g_chain
    assign hit_o[i]          = req_i[i] & none_below[i];
    assign none_below[i + 1] = none_below[i] & ~req_i[i];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < DW; i++)
      if (hit_o[i]) idx_o = idx_o | VW'(i + 1);
  end
endmodule

// File: rtl/intr_status_reg.sv
module intr_status_reg #(
  parameter int          DW       = 16,
  parameter logic [15:0] CLR_MASK = 16'h63E7,
  parameter int          BUSY_BIT = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic          sw_clr_i,
  input  logic [DW-1:0] sw_val_i,
  input  logic          vec_clr_i,
  input  logic [DW-1:0] vec_hit_i,
  output logic [DW-1:0] status_o
);
  localparam logic [DW-1:0] KEEP = ~(DW'(1) << BUSY_BIT);
  localparam logic [DW-1:0] CLRM = DW'(CLR_MASK);

  logic [DW-1:0] clr_vec, status_d;

  always_comb begin
    clr_vec = '0;
    if (sw_clr_i)  clr_vec = clr_vec | (sw_val_i & CLRM);
    if (vec_clr_i) clr_vec = clr_vec | vec_hit_i;
    // set applied after clear: set wins
    status_d = ((status_o & ~clr_vec) | set_i) & KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) status_o <= '0;
    else         status_o <= status_d;
endmodule

// File: rtl/intr_cfg_regs.sv
module intr_cfg_regs #(
  parameter int          DW         = 16,
  parameter logic [15:0] IE_MASK    = 16'h63FF,
  parameter int          RX_RDY_BIT = 3,
  parameter int          TX_RDY_BIT = 4,
  parameter int          RX_DMA_BIT = 15,
  parameter int          TX_DMA_BIT = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ie_wr_i,
  input  logic          cfg_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mask_o,
  output logic          rx_en_o,
  output logic          tx_en_o
);
  localparam logic [DW-1:0] IEM = DW'(IE_MASK);

  logic [DW-1:0] mask_d, drop;

  always_comb begin
    drop = '0;
    drop[RX_RDY_BIT] = wdata_i[RX_DMA_BIT];
    drop[TX_RDY_BIT] = wdata_i[TX_DMA_BIT];
    mask_d = mask_o;
    if (ie_wr_i)       mask_d = wdata_i & IEM;
    else if (cfg_wr_i) mask_d = mask_o & ~drop;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      mask_o  <= '0;
      rx_en_o <= 1'b0;
      tx_en_o <= 1'b0;
    end else begin
      mask_o <= mask_d;
      if (cfg_wr_i) begin
        rx_en_o <= wdata_i[RX_DMA_BIT];
        tx_en_o <= wdata_i[TX_DMA_BIT];
      end
    end
endmodule

// File: rtl/intr_out_stage.sv
module intr_out_stage #(
  parameter int DW         = 16,
  parameter int RX_RDY_BIT = 3,
  parameter int TX_RDY_BIT = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] mask_i,
  input  logic          rx_en_i,
  input  logic          tx_en_i,
  output logic          irq_o,
  output logic          rx_dma_o,
  output logic          tx_dma_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      irq_o    <= 1'b0;
      rx_dma_o <= 1'b0;
      tx_dma_o <= 1'b0;
    end else begin
      irq_o    <= |(status_i & mask_i);
      rx_dma_o <= rx_en_i & status_i[RX_RDY_BIT];
      tx_dma_o <= tx_en_i & status_i[TX_RDY_BIT];
    end
endmodule

// File: rtl/intr_vec_unit.sv
module intr_vec_unit
  import intr_pkg::*;
#(
  parameter int          DW         = 16,
  parameter logic [15:0] CLR_MASK   = 16'h63E7,
  parameter logic [15:0] IE_MASK    = 16'h63FF,
  parameter int          BUSY_BIT   = 12,
  parameter int          RX_RDY_BIT = 3,
  parameter int          TX_RDY_BIT = 4,
  parameter int          RX_DMA_BIT = 15,
  parameter int          TX_DMA_BIT = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic [1:0]    reg_sel_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          bus_busy_i,
  output logic          irq_o,
  output logic          rx_dma_o,
  output logic          tx_dma_o
);
  localparam int VW = $clog2(DW + 1);

  reg_sel_e      sel;
  logic [DW-1:0] status_q, mask_q, pend, hit;
  logic [VW-1:0] vec_idx;
  logic          rx_en_q, tx_en_q;
  logic          stat_wr, ie_wr, cfg_wr, vec_rd;

  assign sel     = reg_sel_e'(reg_sel_i);
  assign stat_wr = reg_wr_i && sel == SEL_STAT;
  assign ie_wr   = reg_wr_i && sel == SEL_IE;
  assign cfg_wr  = reg_wr_i && sel == SEL_CFG;
  assign vec_rd  = reg_rd_i && sel == SEL_VEC;
  assign pend    = status_q & mask_q;

  intr_prio_enc #(.DW(DW)) u_enc (
    .req_i (pend),
    .hit_o (hit),
    .idx_o (vec_idx)
  );

  intr_status_reg #(
    .DW(DW), .CLR_MASK(CLR_MASK), .BUSY_BIT(BUSY_BIT)
  ) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_i),
    .sw_clr_i  (stat_wr),
    .sw_val_i  (wdata_i),
    .vec_clr_i (vec_rd),
    .vec_hit_i (hit),
    .status_o  (status_q)
  );

  intr_cfg_regs #(
    .DW(DW), .IE_MASK(IE_MASK), .RX_RDY_BIT(RX_RDY_BIT),
    .TX_RDY_BIT(TX_RDY_BIT), .RX_DMA_BIT(RX_DMA_BIT), .TX_DMA_BIT(TX_DMA_BIT)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ie_wr_i  (ie_wr),
    .cfg_wr_i (cfg_wr),
    .wdata_i  (wdata_i),
    .mask_o   (mask_q),
    .rx_en_o  (rx_en_q),
    .tx_en_o  (tx_en_q)
  );

  intr_out_stage #(
    .DW(DW), .RX_RDY_BIT(RX_RDY_BIT), .TX_RDY_BIT(TX_RDY_BIT)
  ) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_q),
    .mask_i   (mask_q),
    .rx_en_i  (rx_en_q),
    .tx_en_i  (tx_en_q),
    .irq_o    (irq_o),
    .rx_dma_o (rx_dma_o),
    .tx_dma_o (tx_dma_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_STAT: begin
        rdata_o           = status_q;
        rdata_o[BUSY_BIT] = bus_busy_i;
      end
      SEL_IE:   rdata_o = mask_q;
      SEL_VEC:  rdata_o[VW-1:0] = vec_idx;
      SEL_CFG: begin
        rdata_o[RX_DMA_BIT] = rx_en_q;
        rdata_o[TX_DMA_BIT] = tx_en_q;
      end
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/intr_vec_unit_chk.sv
module intr_vec_unit_chk #(
  parameter int          DW         = 16,
  parameter logic [15:0] CLR_MASK   = 16'h63E7,
  parameter logic [15:0] IE_MASK    = 16'h63FF,
  parameter int          BUSY_BIT   = 12,
  parameter int          RX_RDY_BIT = 3,
  parameter int          TX_RDY_BIT = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] set_i,
  input logic [DW-1:0] status_q,
  input logic [DW-1:0] mask_q,
  input logic          rx_en_q,
  input logic          tx_en_q,
  input logic          vec_rd,
  input logic          irq_o,
  input logic          rx_dma_o,
  input logic          tx_dma_o
);
  localparam logic [DW-1:0] HW_ONLY = ~DW'(CLR_MASK);
  localparam logic [DW-1:0] NOBUSY  = ~(DW'(1) << BUSY_BIT);

  a_r2_busy_not_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_q[BUSY_BIT] == 1'b0);

  a_r4_hw_only_bits_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_rd |=> ((status_q & HW_ONLY) & $past(status_q)) == ($past(status_q) & HW_ONLY));

  a_r5_mask_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q & ~DW'(IE_MASK)) == '0);

  a_r6_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == |($past(status_q) & $past(mask_q)));

  a_r8_rx_dma: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> rx_dma_o == ($past(status_q[RX_RDY_BIT]) && $past(rx_en_q)));

  a_r8_tx_dma: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> tx_dma_o == ($past(status_q[TX_RDY_BIT]) && $past(tx_en_q)));

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(set_i & NOBUSY) |=> (status_q & $past(set_i & NOBUSY)) == $past(set_i & NOBUSY));

  a_r7_vec_one_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_rd |=> $countones($past(status_q) & ~status_q) <= 1);
endmodule

bind intr_vec_unit intr_vec_unit_chk #(
  .DW(DW), .CLR_MASK(CLR_MASK), .IE_MASK(IE_MASK), .BUSY_BIT(BUSY_BIT),
  .RX_RDY_BIT(RX_RDY_BIT), .TX_RDY_BIT(TX_RDY_BIT)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .set_i    (set_i),
  .status_q (status_q),
  .mask_q   (mask_q),
  .rx_en_q  (rx_en_q),
  .tx_en_q  (tx_en_q),
  .vec_rd   (vec_rd),
  .irq_o    (irq_o),
  .rx_dma_o (rx_dma_o),
  .tx_dma_o (tx_dma_o)
);

// File: tb/tb_intr_vec_unit.sv
`timescale 1ns/1ps
module tb_intr_vec_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] set_i = '0;
  logic [1:0]  reg_sel_i = '0;
  logic        reg_wr_i = 1'b0;
  logic        reg_rd_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        bus_busy_i = 1'b0;
  logic        irq_o, rx_dma_o, tx_dma_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  intr_vec_unit dut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    reg_sel_i = sel; wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] sel, output logic [15:0] d);
    reg_sel_i = sel; reg_rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    reg_rd_i = 1'b0;
  endtask

  task automatic pulse(logic [15:0] b);
    set_i = b;
    @(negedge clk_i);
    set_i = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd0, d); chk("R1 status", d, 16'h0000);
    rd(2'd1, d); chk("R1 enable", d, 16'h0000);
    rd(2'd3, d); chk("R1 cfg", d, 16'h0000);
    chk("R1 outputs", {13'd0, irq_o, rx_dma_o, tx_dma_o}, 16'h0000);
  endtask

  task automatic t_busy();
    logic [15:0] d;
    bus_busy_i = 1'b1;
    rd(2'd0, d); chk("R3 busy live", d, 16'h1000);
    bus_busy_i = 1'b0;
    pulse(16'h1000);
    rd(2'd0, d); chk("R2 bit12 not stored", d, 16'h0000);
  endtask

  task automatic t_set_clear();
    logic [15:0] d;
    pulse(16'h0802);
    rd(2'd0, d); chk("R2 set", d, 16'h0802);
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d); chk("R4 w1c masked", d, 16'h0800);
    pulse(16'h0018);
    wr(2'd0, 16'h0018);
    rd(2'd0, d); chk("R4 ready bits hw only", d, 16'h0818);
  endtask

  task automatic t_enable_vector();
    logic [15:0] d;
    wr(2'd1, 16'hFFFF);
    rd(2'd1, d); chk("R5 enable mask", d, 16'h63FF);
    chk("R6 irq asserted", {15'd0, irq_o}, 16'h0001);
    rd(2'd2, d); chk("R7 vector bit3", d, 16'd4);
    rd(2'd2, d); chk("R7 vector bit4", d, 16'd5);
    chk("R6 irq one cycle late", {15'd0, irq_o}, 16'h0001);
    cyc(1);
    chk("R6 irq cleared", {15'd0, irq_o}, 16'h0000);
    rd(2'd2, d); chk("R7 vector none", d, 16'd0);
    rd(2'd0, d); chk("R7 cleared bits", d, 16'h0800);
  endtask

  task automatic t_dma();
    logic [15:0] d;
    wr(2'd3, 16'h8080);
    rd(2'd1, d); chk("R9 ready enables cleared", d, 16'h63E7);
    rd(2'd3, d); chk("R8 cfg readback", d, 16'h8080);
    pulse(16'h0008);
    chk("R8 rx dma latency", {14'd0, rx_dma_o, tx_dma_o}, 16'h0000);
    cyc(1);
    chk("R8 rx dma asserted", {14'd0, rx_dma_o, tx_dma_o}, 16'h0002);
    chk("R9 no irq for rx ready", {15'd0, irq_o}, 16'h0000);
    wr(2'd3, 16'h0000);
    cyc(1);
    chk("R8 rx dma gated off", {14'd0, rx_dma_o, tx_dma_o}, 16'h0000);
    wr(2'd3, 16'h0080);
    pulse(16'h0010);
    cyc(1);
    chk("R8 tx dma asserted", {14'd0, rx_dma_o, tx_dma_o}, 16'h0001);
    rd(2'd1, d); chk("R9 tx enable cleared", d, 16'h63E7);
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    pulse(16'h0002);
    set_i = 16'h0002;
    wr(2'd0, 16'h0002);
    set_i = '0;
    rd(2'd0, d); chk("R10 set beats w1c", d, 16'h081A);
    wr(2'd1, 16'h0002);
    set_i = 16'h0002;
    rd(2'd2, d);
    set_i = '0;
    chk("R10 vector value", d, 16'd2);
    rd(2'd0, d); chk("R10 set beats vector clear", d, 16'h081A);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    t_reset();
    t_busy();
    t_set_clear();
    t_enable_vector();
    t_dma();
    t_set_wins();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule